// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one 8-bit input port with a full strobed handshake. A peripheral places a byte on the data pins and pulls an active-low strobe. On the falling edge of that strobe the port latches the byte and raises the buffer-full flag (IBF). Once the strobe is released, the port raises an interrupt request (INTR) toward the host, provided the buffer still holds the byte and the interrupt-enable flip-flop (INTE) is set.

The host collects the byte with an active-low read strobe. The falling edge of the read drops INTR and captures the latched byte onto the read-data output. The rising edge of the read clears IBF. INTE is written only by port-C bit set/reset commands. The port that takes commands for bit index 4 is the default; the parameter `PORT_B` selects the variant that takes them for index 2 instead.

The peripheral strobe, the peripheral data and the host read all cross into the clock domain through a `SYNC_STAGES`-deep synchronizer. A controller then tracks the handshake in five states:

| State | Meaning |
|---|---|
| `ST_EMPTY` | The buffer holds no byte. |
| `ST_STROBE` | A byte is latched and the strobe is still low. |
| `ST_FULL` | A byte is latched and the strobe has been released. |
| `ST_READ` | A host read is in progress. |
| `ST_READ_NEW` | A host read is in progress and a new byte arrived during it. |

The controller moves between these states as follows:

| From | Event | To |
|---|---|---|
| `ST_EMPTY` | Strobe fall | `ST_STROBE` |
| `ST_EMPTY` | Read fall | `ST_READ` |
| `ST_EMPTY` | Read fall together with strobe fall | `ST_READ_NEW` |
| `ST_STROBE` | Strobe rise | `ST_FULL` |
| `ST_STROBE` | Read fall | `ST_READ` |
| `ST_FULL` | Strobe fall | `ST_STROBE` |
| `ST_FULL` | Read fall | `ST_READ` |
| `ST_FULL` | Read fall together with strobe fall | `ST_READ_NEW` |
| `ST_READ` | Read rise | `ST_EMPTY` |
| `ST_READ` | Strobe fall | `ST_READ_NEW` |
| `ST_READ` | Read rise together with strobe fall | `ST_STROBE` |
| `ST_READ_NEW` | Read rise, strobe high | `ST_FULL` |
| `ST_READ_NEW` | Read rise, strobe low | `ST_STROBE` |

Top module: `strobed_in_port`

## Requirements
- R1: After reset, `ibf_o` is 0 and `intr_o` is 0. INTE is cleared, so a byte strobed in after reset does not raise `intr_o` until INTE is set.
- R2: A falling edge on `stb_n_i` latches the value present on `pdata_i` and sets `ibf_o`. Later changes on `pdata_i` do not alter the latched byte.
- R3: `intr_o` is 1 only while the strobe is released, `ibf_o` is 1 and INTE is 1. While `stb_n_i` is held low, `intr_o` stays 0.
- R4: A falling edge on `rd_n_i` drops `intr_o` and loads `rdata_o` with the latched byte. `rdata_o` holds that value until the next falling edge of `rd_n_i`.
- R5: A rising edge on `rd_n_i` clears `ibf_o`, unless a new byte arrived during the read.
- R6: When `bsr_we_i` is 1, INTE takes the value of `bsr_val_i` (1 sets, 0 clears) only if `bsr_bit_i` equals 4 (or 2 when `PORT_B`=1). Commands for any other bit index leave INTE and `intr_o` unchanged. Clearing INTE while the buffer is full drops `intr_o`.
- R7: A strobe that arrives while `ibf_o` is already 1 overwrites the latched byte. The next read returns the newer byte.
- R8: A strobe during a host read latches its byte and keeps `ibf_o` at 1 after the read ends. With the strobe released, `intr_o` then returns to 1.
- R9: When a strobe fall and a read fall land in the same cycle, the read returns the byte latched before that strobe. The new byte stays buffered with `ibf_o` at 1 for the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| pdata_i | input | 8 | Peripheral data byte |
| stb_n_i | input | 1 | Peripheral strobe, active low |
| rd_n_i | input | 1 | Host read strobe, active low |
| bsr_we_i | input | 1 | Port-C bit set/reset command valid |
| bsr_bit_i | input | 3 | Port-C bit index of the command |
| bsr_val_i | input | 1 | 1 sets the addressed bit, 0 clears it |
| rdata_o | output | 8 | Byte returned to the host |
| ibf_o | output | 1 | Input buffer full |
| intr_o | output | 1 | Interrupt request to the host |

## Verification
The collision of interest is a peripheral strobe fall landing in the same cycle as a host read fall (and, symmetrically, a strobe fall against a read rise). The bench provokes the first by driving `stb_n_i`, the new data byte and `rd_n_i` on the same clock edge. Because all three share the same synchronizer depth, the edges reach the controller together. The result is judged at the ports: `rdata_o` must show the previously buffered byte, and `ibf_o` must stay set after the read ends. A second read must then return the new byte and clear the flag.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_STROBE   = 3'd1,
        ST_FULL     = 3'd2,
        ST_READ     = 3'd3,
        ST_READ_NEW = 3'd4
    } hsk_state_e;

    // Port-C bit that owns this port's interrupt enable
    function automatic logic [2:0] inte_index(input bit port_b);
        return port_b ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/hsk_edge.sv
module hsk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
    assign rise = ~prev_q & lvl;

endmodule

// File: rtl/hsk_inte_reg.sv
module hsk_inte_reg #(
    parameter int         IDX_W    = 3,
    parameter logic [2:0] INTE_BIT = 3'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bsr_we,
    input  logic [IDX_W-1:0] bsr_bit,
    input  logic             bsr_val,
    output logic             inte
);
    localparam logic [IDX_W-1:0] MATCH = IDX_W'(INTE_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            inte <= 1'b0;
        else if (bsr_we && bsr_bit == MATCH)   inte <= bsr_val;
    end

endmodule

// File: rtl/hsk_ctrl_fsm.sv
module hsk_ctrl_fsm
    import hsk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_s,
    input  logic              stb_lvl,
    input  logic              stb_fall,
    input  logic              stb_rise,
    input  logic              rd_fall,
    input  logic              rd_rise,
    input  logic              inte,
    output logic [DATA_W-1:0] rdata,
    output logic              ibf,
    output logic              intr
);
    hsk_state_e state_q, state_d;
    logic [DATA_W-1:0] latch_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (rd_fall)       state_d = stb_fall ? ST_READ_NEW : ST_READ;
                else if (stb_fall) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (rd_fall)       state_d = ST_READ;
                else if (stb_rise) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (rd_fall)       state_d = stb_fall ? ST_READ_NEW : ST_READ;
                else if (stb_fall) state_d = ST_STROBE;
            end
            ST_READ: begin
                if (rd_rise)       state_d = stb_fall ? ST_STROBE : ST_EMPTY;
                else if (stb_fall) state_d = ST_READ_NEW;
            end
            ST_READ_NEW: begin
                if (rd_rise)       state_d = stb_lvl ? ST_FULL : ST_STROBE;
            end
            default:               state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        ibf  = 1'b1;
        intr = 1'b0;
        unique case (state_q)
            ST_EMPTY:    ibf = 1'b0;
            ST_FULL:     intr = inte;
            ST_STROBE,
            ST_READ,
            ST_READ_NEW: ibf = 1'b1;
            default:     ibf = 1'b0;
        endcase
    end

    // data path: capture on strobe fall, snapshot on read fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            rdata   <= '0;
        end else begin
            if (stb_fall) latch_q <= data_s;
            if (rd_fall)  rdata   <= latch_q;
        end
    end

endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
    import hsk_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 3,
    parameter bit PORT_B      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pdata_i,
    input  logic              stb_n_i,
    input  logic              rd_n_i,
    input  logic              bsr_we_i,
    input  logic [IDX_W-1:0]  bsr_bit_i,
    input  logic              bsr_val_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ibf_o,
    output logic              intr_o
);
    localparam logic [2:0] INTE_BIT = inte_index(PORT_B);
    localparam int         CTL_W    = 2;

    logic [DATA_W-1:0] data_s;
    logic [CTL_W-1:0]  ctl_s;
    logic              stb_lvl, rd_lvl;
    logic              stb_fall, stb_rise, rd_fall, rd_rise;
    logic              inte;

    hsk_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .d(pdata_i), .q(data_s)
    );

    hsk_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({rd_n_i, stb_n_i}), .q(ctl_s)
    );

    assign stb_lvl = ctl_s[0];
    assign rd_lvl  = ctl_s[1];

    hsk_edge u_stb_edge (
        .clk(clk), .rst_n(rst_n), .lvl(stb_lvl), .fall(stb_fall), .rise(stb_rise)
    );

    hsk_edge u_rd_edge (
        .clk(clk), .rst_n(rst_n), .lvl(rd_lvl), .fall(rd_fall), .rise(rd_rise)
    );

    hsk_inte_reg #(.IDX_W(IDX_W), .INTE_BIT(INTE_BIT)) u_inte (
        .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we_i), .bsr_bit(bsr_bit_i),
        .bsr_val(bsr_val_i), .inte(inte)
    );

    hsk_ctrl_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .data_s(data_s), .stb_lvl(stb_lvl),
        .stb_fall(stb_fall), .stb_rise(stb_rise), .rd_fall(rd_fall),
        .rd_rise(rd_rise), .inte(inte), .rdata(rdata_o), .ibf(ibf_o),
        .intr(intr_o)
    );

endmodule

// File: rtl/strobed_in_port_chk.sv
module strobed_in_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stb_fall,
    input logic              rd_fall,
    input logic              rd_rise,
    input logic [DATA_W-1:0] rdata,
    input logic              ibf,
    input logic              intr
);
    // R3
    intr_needs_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ibf);

    // R3
    strobe_low_no_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> !intr);

    // R2
    strobe_sets_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_fall |=> ibf);

    // R4
    read_drops_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fall |=> !intr);

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fall |=> $stable(rdata));

    // R5
    ibf_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ibf) |-> $past(rd_rise));

endmodule

bind strobed_in_port strobed_in_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stb_fall(stb_fall), .rd_fall(rd_fall),
    .rd_rise(rd_rise), .rdata(rdata_o), .ibf(ibf_o), .intr(intr_o)
);

// File: tb/strobed_in_port_tb.sv
`timescale 1ns/1ps
module strobed_in_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pdata = 8'h00;
    logic       stb_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       bsr_we = 1'b0;
    logic [2:0] bsr_bit = 3'd0;
    logic       bsr_val = 1'b0;
    logic [7:0] rdata;
    logic       ibf, intr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    strobed_in_port dut_i (
        .clk(clk), .rst_n(rst_n), .pdata_i(pdata), .stb_n_i(stb_n),
        .rd_n_i(rd_n), .bsr_we_i(bsr_we), .bsr_bit_i(bsr_bit),
        .bsr_val_i(bsr_val), .rdata_o(rdata), .ibf_o(ibf), .intr_o(intr)
    );

    // op codes
    localparam logic [2:0] OP_BSR = 3'd0, OP_SLO = 3'd1, OP_SHI = 3'd2,
                           OP_RLO = 3'd3, OP_RHI = 3'd4;
    // {op, data, bit, val, exp_ibf, exp_intr, chk_rd, exp_rd}
    localparam int NV = 18;
    localparam logic [25:0] VEC [NV] = '{
        {OP_BSR, 8'h00, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R6 enable
        {OP_SLO, 8'hA5, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2 R3
        {OP_SHI, 8'h00, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00}, // R3
        {OP_RLO, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5}, // R4 R2
        {OP_RHI, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R5
        {OP_SLO, 8'h3C, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R2
        {OP_SHI, 8'h3C, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00}, // R3
        {OP_SLO, 8'hC3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R7
        {OP_SHI, 8'hC3, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00}, // R7
        {OP_BSR, 8'hC3, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 other bit
        {OP_BSR, 8'hC3, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 clear
        {OP_BSR, 8'hC3, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 set
        {OP_RLO, 8'hC3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3}, // R7 R4
        {OP_SLO, 8'h5A, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3}, // R8 R4
        {OP_SHI, 8'h5A, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hC3}, // R8
        {OP_RHI, 8'h5A, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 8'hC3}, // R8
        {OP_RLO, 8'h5A, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A}, // R8
        {OP_RHI, 8'h5A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A}  // R5
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bsr(input logic [2:0] b, input logic v);
        @(negedge clk);
        bsr_we = 1'b1; bsr_bit = b; bsr_val = v;
        @(negedge clk);
        bsr_we = 1'b0;
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] d,
                         input logic [2:0] b, input logic v);
        case (op)
            OP_BSR: bsr(b, v);
            OP_SLO: begin @(negedge clk); pdata = d; stb_n = 1'b0; end
            OP_SHI: begin @(negedge clk); pdata = d; stb_n = 1'b1; end
            OP_RLO: begin @(negedge clk); rd_n = 1'b0; end
            default: begin @(negedge clk); rd_n = 1'b1; end
        endcase
        settle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({7'd0, ibf},  8'd0, "R1", "ibf in reset");
        chk({7'd0, intr}, 8'd0, "R1", "intr in reset");
        rst_n = 1'b1;
        settle();
        chk({7'd0, ibf},  8'd0, "R1", "ibf after reset");

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            apply(v[25:23], v[22:15], v[14:12], v[11]);
            chk({7'd0, ibf},  {7'd0, v[10]}, "R2-R8 table", $sformatf("ibf row %0d", i));
            chk({7'd0, intr}, {7'd0, v[9]},  "R3-R8 table", $sformatf("intr row %0d", i));
            if (v[8]) chk(rdata, v[7:0], "R4 table", $sformatf("rdata row %0d", i));
        end

        // R9 coincident strobe fall and read fall
        apply(OP_SLO, 8'h11, 3'd0, 1'b0);
        apply(OP_SHI, 8'h11, 3'd0, 1'b0);
        chk({7'd0, intr}, 8'd1, "R9", "intr before collision");
        @(negedge clk);
        pdata = 8'h22; stb_n = 1'b0; rd_n = 1'b0;
        settle();
        chk(rdata, 8'h11, "R9", "read returns prior byte");
        chk({7'd0, ibf},  8'd1, "R9", "ibf during collision read");
        chk({7'd0, intr}, 8'd0, "R9", "intr during collision read");
        apply(OP_RHI, 8'h22, 3'd0, 1'b0);
        chk({7'd0, ibf}, 8'd1, "R9", "ibf kept after read");
        apply(OP_SHI, 8'h22, 3'd0, 1'b0);
        chk({7'd0, intr}, 8'd1, "R9", "intr after release");
        apply(OP_RLO, 8'h22, 3'd0, 1'b0);
        chk(rdata, 8'h22, "R9", "second read returns new byte");
        apply(OP_RHI, 8'h22, 3'd0, 1'b0);
        chk({7'd0, ibf}, 8'd0, "R5", "ibf cleared");

        // R2 data change after strobe fall is not captured
        apply(OP_SLO, 8'h66, 3'd0, 1'b0);
        @(negedge clk); pdata = 8'h99;
        settle();
        apply(OP_SHI, 8'h99, 3'd0, 1'b0);
        apply(OP_RLO, 8'h99, 3'd0, 1'b0);
        chk(rdata, 8'h66, "R2", "latched byte");
        apply(OP_RHI, 8'h99, 3'd0, 1'b0);

        // R1 mid-operation reset clears state and INTE
        apply(OP_SLO, 8'h77, 3'd0, 1'b0);
        apply(OP_SHI, 8'h77, 3'd0, 1'b0);
        chk({7'd0, intr}, 8'd1, "R1", "intr before reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk({7'd0, ibf},  8'd0, "R1", "ibf on reset");
        chk({7'd0, intr}, 8'd0, "R1", "intr on reset");
        rst_n = 1'b1;
        apply(OP_SLO, 8'h88, 3'd0, 1'b0);
        apply(OP_SHI, 8'h88, 3'd0, 1'b0);
        chk({7'd0, ibf},  8'd1, "R1", "ibf after strobe");
        chk({7'd0, intr}, 8'd0, "R1", "INTE cleared by reset");
        // R6 bit index 6 must not enable
        bsr(3'd6, 1'b1);
        settle();
        chk({7'd0, intr}, 8'd0, "R6", "wrong index ignored");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule